// File: doc/BRIEF.md
# Coprocessor Interrupt Latch and Control Registers

This block is the software-visible register front end of a small coprocessor. It holds a flags word and a control word on a synchronous 32-bit register bus. It also exposes a read-only remainder word, which the core's divider supplies. The flags word carries the condition codes and a five-bit interrupt enable mask. The control word carries the run bit that starts and stops the core.

Five external interrupt lines are latched into a field inside the control word. The latched requests are gated by the enable mask and by the run bit. The result is a pending indication and the number of the highest pending source, which the core's vectoring logic uses. Software acknowledges a request by writing ones to a group of clear bits in the flags word. Those clear bits are never stored. A control write changes only the bits that software may own. The latch field and a fixed group of upper bits keep their values.

Top module: `cop_irq_regs`

## Requirements
- R1: After reset, the control word reads 0x00002800 and the flags word reads 0. `bus_rdata`, `run_bit`, `irq_pending` and `irq_src` are all 0.
- R2: A read strobe at byte offset 0x00 returns the flags word, at 0x14 the control word, and at 0x1C the value of `remain_in`. The data appears on `bus_rdata` in the cycle after the strobe and holds until the next read.
- R3: A read at any offset whose two low bits are not 00 returns 0. A read at any offset other than 0x00, 0x14 and 0x1C also returns 0.
- R4: A flags write stores the written data, but bits 9 to 13 are forced to 0, so a flags read equals the data written ANDed with 0xFFFFC1FF. `flag_z`, `flag_c` and `flag_n` show flags bits 0, 1 and 2. Flags bits 4+n form the enable for source n.
- R5: A rising edge on `irq_line[n]` sets the latch for source n. A falling edge clears it. The latch reads back as control bit 6+n, and the latch updates at the clock edge that samples the new line level.
- R6: A flags write with bit 9+n set clears latch n, even while the line stays high. If a rising edge on line n arrives in the same cycle, the set wins.
- R7: A control write keeps bits 6 to 10 (the latches) and bits 12 to 15 at their old values. Every other bit takes the written data: the new stored word is (old AND 0xF7C0) OR (data AND NOT 0xF7C0).
- R8: `run_bit` equals control bit 0. It changes only on a control write.
- R9: `irq_pending` is 1 exactly when `run_bit` is 1 and the latch field ANDed with the enable mask is nonzero.
- R10: `irq_src` gives the highest source number n whose latch and enable bits are both 1 while `run_bit` is 1. It is 0 when `irq_pending` is 0.
- R11: Writes to any offset other than 0x00 and 0x14, including unaligned offsets, change neither the flags word nor the control word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| remain_in | input | 32 | Remainder value from the divider, returned at offset 0x1C |
| irq_line | input | 5 | External interrupt lines, synchronous to clk |
| run_bit | output | 1 | Core run control (control bit 0) |
| flag_z | output | 1 | Zero condition code (flags bit 0) |
| flag_c | output | 1 | Carry condition code (flags bit 1) |
| flag_n | output | 1 | Negative condition code (flags bit 2) |
| irq_pending | output | 1 | An enabled, latched request exists while running |
| irq_src | output | 3 | Highest pending source number |

## Verification
Two cases are hard to bring about from the ports. In one, a clear bit removes a latch whose line is still held high. In the other, a clear and a new rising edge on the same source land in the same cycle. The stimulus first raises every line and then writes clear patterns while the lines stay up. Next it lowers one line, then raises it again in the very cycle that a flags write asks to clear that source. A further sweep walks all 32 enable masks against all 32 line patterns. The order of the line patterns lets every latch see both rising and falling edges. Each step is scored against the highest-set-bit arithmetic.

// File: rtl/cop_irq_pkg.sv
// Package: shared constants for the coprocessor interrupt and control registers.
// Assumes a 32-bit data path and byte offsets on a 5-bit address.
package cop_irq_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 5;
    localparam int NUM_SRC = 5;

    // Field positions; the clear group sits three above the latch group.
    localparam int CC_Z_BIT  = 0;
    localparam int CC_C_BIT  = 1;
    localparam int CC_N_BIT  = 2;
    localparam int EN_LSB    = 4;
    localparam int LATCH_LSB = 6;
    localparam int CLR_LSB   = 9;

    localparam logic [ADDR_W-1:0] OFF_FLAGS  = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 5'h14;
    localparam logic [ADDR_W-1:0] OFF_REMAIN = 5'h1C;

    localparam logic [DATA_W-1:0] SRC_ONES      = DATA_W'((1 << NUM_SRC) - 1);
    localparam logic [DATA_W-1:0] LATCH_FIELD   = SRC_ONES << LATCH_LSB;
    localparam logic [DATA_W-1:0] FIXED_GROUP   = 32'h0000_F000;
    localparam logic [DATA_W-1:0] CTRL_KEEP     = LATCH_FIELD | FIXED_GROUP;
    localparam logic [DATA_W-1:0] FLAGS_RD_MASK = ~(SRC_ONES << CLR_LSB);
    localparam logic [DATA_W-1:0] CTRL_RESET    = 32'h0000_2800;
endpackage

// File: rtl/cop_irq_latch_bank.sv
// Module: one latch per interrupt source.
// A rising line edge sets the latch, and a falling edge or a clear request resets it.
// A rising edge wins over a clear in the same cycle.
// Assumes the lines are already synchronous to clk.
module cop_irq_latch_bank #(
    parameter int NUM_SRC = cop_irq_pkg::NUM_SRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_line,
    input  logic [NUM_SRC-1:0] clr_req,
    output logic [NUM_SRC-1:0] latch_q
);
    logic [NUM_SRC-1:0] line_q;

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
        logic rise;
        logic fall;
        assign rise = irq_line[n] & ~line_q[n];
        assign fall = ~irq_line[n] & line_q[n];

        // Track the previous line level and update the latch from edges and clears.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_q[n]  <= 1'b0;
                latch_q[n] <= 1'b0;
            end else begin
                line_q[n] <= irq_line[n];
                if (rise)
                    latch_q[n] <= 1'b1;
                else if (fall || clr_req[n])
                    latch_q[n] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cop_irq_prio.sv
// Module: gates the latched requests by the enables and the run bit, then encodes
// the highest-numbered pending source. Purely combinational.
module cop_irq_prio #(
    parameter int NUM_SRC = cop_irq_pkg::NUM_SRC,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] latch_q,
    input  logic [NUM_SRC-1:0] en_mask,
    input  logic               run,
    output logic               pending,
    output logic [SRC_W-1:0]   src
);
    logic [NUM_SRC-1:0] gated;

    // Form the qualified requests and select the highest set one.
    always_comb begin
        gated = latch_q & en_mask & {NUM_SRC{run}};
        src   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (gated[i])
                src = SRC_W'(i);
        end
        pending = |gated;
    end
endmodule

// File: rtl/cop_irq_regfile.sv
// Module: flags and control storage, address decode and the registered read port.
// It assumes a synchronous bus in which a read strobe returns data one cycle later.
// The latch field of the control word comes from the latch bank. It is never stored here.
module cop_irq_regfile
    import cop_irq_pkg::*;
#(
    parameter int DATA_W  = cop_irq_pkg::DATA_W,
    parameter int ADDR_W  = cop_irq_pkg::ADDR_W,
    parameter int NUM_SRC = cop_irq_pkg::NUM_SRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [DATA_W-1:0]  remain_in,
    input  logic [NUM_SRC-1:0] latch_q,
    output logic [NUM_SRC-1:0] clr_req,
    output logic [NUM_SRC-1:0] en_mask,
    output logic [2:0]         cc,
    output logic               run,
    output logic [DATA_W-1:0]  bus_rdata
);
    logic [DATA_W-1:0] flags_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] ctrl_word;
    logic [DATA_W-1:0] rd_sel;
    logic              flags_wr;
    logic              ctrl_wr;

    assign flags_wr  = bus_wr && (bus_addr == OFF_FLAGS);
    assign ctrl_wr   = bus_wr && (bus_addr == OFF_CTRL);
    assign clr_req   = flags_wr ? bus_wdata[CLR_LSB +: NUM_SRC] : '0;
    assign en_mask   = flags_q[EN_LSB +: NUM_SRC];
    assign cc        = {flags_q[CC_N_BIT], flags_q[CC_C_BIT], flags_q[CC_Z_BIT]};
    assign ctrl_word = ctrl_q | (DATA_W'(latch_q) << LATCH_LSB);
    assign run       = ctrl_q[0];

    // Flags storage; the clear group is never kept.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else if (flags_wr)
            flags_q <= bus_wdata & FLAGS_RD_MASK;
    end

    // Control storage; the protected bits keep their old value on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= CTRL_RESET;
        else if (ctrl_wr)
            ctrl_q <= (ctrl_q & CTRL_KEEP) | (bus_wdata & ~CTRL_KEEP);
    end

    // Read multiplexer over the mapped word offsets.
    always_comb begin
        unique case (bus_addr)
            OFF_FLAGS:  rd_sel = flags_q;
            OFF_CTRL:   rd_sel = ctrl_word;
            OFF_REMAIN: rd_sel = remain_in;
            default:    rd_sel = '0;
        endcase
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_sel;
    end
endmodule

// File: rtl/cop_irq_regs.sv
// Module: top of the coprocessor interrupt latch and control register block.
// It wires the register file, the latch bank and the priority encoder together.
// Assumes the bus and the interrupt lines are synchronous to clk.
module cop_irq_regs #(
    parameter int DATA_W  = cop_irq_pkg::DATA_W,
    parameter int ADDR_W  = cop_irq_pkg::ADDR_W,
    parameter int NUM_SRC = cop_irq_pkg::NUM_SRC,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [DATA_W-1:0]  remain_in,
    input  logic [NUM_SRC-1:0] irq_line,
    output logic               run_bit,
    output logic               flag_z,
    output logic               flag_c,
    output logic               flag_n,
    output logic               irq_pending,
    output logic [SRC_W-1:0]   irq_src
);
    logic [NUM_SRC-1:0] latch_q;
    logic [NUM_SRC-1:0] clr_req;
    logic [NUM_SRC-1:0] en_mask;
    logic [2:0]         cc;

    assign flag_z = cc[0];
    assign flag_c = cc[1];
    assign flag_n = cc[2];

    cop_irq_regfile #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .NUM_SRC(NUM_SRC)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .remain_in(remain_in),
        .latch_q  (latch_q),
        .clr_req  (clr_req),
        .en_mask  (en_mask),
        .cc       (cc),
        .run      (run_bit),
        .bus_rdata(bus_rdata)
    );

    cop_irq_latch_bank #(
        .NUM_SRC(NUM_SRC)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_line(irq_line),
        .clr_req (clr_req),
        .latch_q (latch_q)
    );

    cop_irq_prio #(
        .NUM_SRC(NUM_SRC)
    ) u_prio (
        .latch_q(latch_q),
        .en_mask(en_mask),
        .run    (run_bit),
        .pending(irq_pending),
        .src    (irq_src)
    );
endmodule

// File: rtl/cop_irq_regs_chk.sv
// Module: assertion checker for cop_irq_regs, attached by the bind at the end of this file.
// It observes the ports and the internal latch vector. It drives nothing.
module cop_irq_regs_chk
    import cop_irq_pkg::*;
#(
    parameter int DATA_W  = cop_irq_pkg::DATA_W,
    parameter int ADDR_W  = cop_irq_pkg::ADDR_W,
    parameter int NUM_SRC = cop_irq_pkg::NUM_SRC,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic               wr_run,
    input logic [NUM_SRC-1:0] wr_clr,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_SRC-1:0] irq_line,
    input logic [NUM_SRC-1:0] latch_q,
    input logic               run_bit,
    input logic               irq_pending,
    input logic [SRC_W-1:0]   irq_src
);
    AST_RD_UNALIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr[1:0] != 2'b00)) |=> (bus_rdata == '0)); // R3

    AST_FLAGS_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == OFF_FLAGS)) |=> (bus_rdata[CLR_LSB +: NUM_SRC] == '0)); // R4

    AST_RUN_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == OFF_CTRL)) |=> (run_bit == $past(wr_run))); // R8

    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == OFF_CTRL)) |=> $stable(run_bit)); // R8

    AST_PENDING_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> run_bit); // R9

    AST_SRC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_pending |-> (irq_src == '0)); // R10

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
        AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_line[n]) |=> latch_q[n]); // R5

        AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq_line[n]) |=> !latch_q[n]); // R5

        AST_CLEAR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && (bus_addr == OFF_FLAGS) && wr_clr[n] && !irq_line[n]) |=> !latch_q[n]); // R6
    end
endmodule

bind cop_irq_regs cop_irq_regs_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .NUM_SRC(NUM_SRC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .wr_run     (bus_wdata[0]),
    .wr_clr     (bus_wdata[cop_irq_pkg::CLR_LSB +: NUM_SRC]),
    .bus_rdata  (bus_rdata),
    .irq_line   (irq_line),
    .latch_q    (latch_q),
    .run_bit    (run_bit),
    .irq_pending(irq_pending),
    .irq_src    (irq_src)
);

// File: tb/cop_irq_regs_tb.sv
// Bench: self-checking sweeps over the register block with arithmetic expectations.
module cop_irq_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] KEEP  = 32'h0000_F7C0;
    localparam logic [31:0] FHOLD = 32'h0000_F000;
    localparam logic [31:0] FMASK = 32'hFFFF_C1FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] remain_in = '0;
    logic [4:0]  irq_line = '0;
    logic        run_bit, flag_z, flag_c, flag_n, irq_pending;
    logic [2:0]  irq_src;

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] m_ctrl;
    logic [31:0] m_flags;
    logic [31:0] rv;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cop_irq_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .remain_in(remain_in), .irq_line(irq_line), .run_bit(run_bit),
        .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n),
        .irq_pending(irq_pending), .irq_src(irq_src)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Each task starts and ends at a falling edge.
    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic ctrl_write(input logic [31:0] d);
        bus_write(5'h14, d);
        m_ctrl = (m_ctrl & FHOLD) | (d & ~KEEP);
    endtask

    function automatic logic [31:0] top_src(input logic [4:0] p);
        logic [31:0] r = 0;
        for (int k = 0; k < 5; k++) if (p[k]) r = k;
        return r;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        m_ctrl = 32'h0000_2800;
        m_flags = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rdata", bus_rdata, 0);
        chk("R1 run", {31'd0, run_bit}, 0);
        chk("R1 pending", {31'd0, irq_pending}, 0);
        chk("R1 src", {29'd0, irq_src}, 0);
        bus_read(5'h14, rv); chk("R1 ctrl", rv, 32'h0000_2800);
        bus_read(5'h00, rv); chk("R1 flags", rv, 0);

        // R7 and R8: control write sweep
        for (int i = 0; i < 64; i++) begin
            logic [31:0] d;
            d = (32'(i) * 32'h9E37_79B9) ^ (32'(i) << 11);
            ctrl_write(d);
            chk("R8 run follows bit0", {31'd0, run_bit}, {31'd0, d[0]});
            bus_read(5'h14, rv); chk("R7 ctrl masked write", rv, m_ctrl);
        end
        ctrl_write(32'hFFFF_FFFF);
        bus_read(5'h14, rv); chk("R7 ctrl all ones", rv, m_ctrl);
        ctrl_write(32'h0);
        bus_read(5'h14, rv); chk("R7 ctrl zeros", rv, m_ctrl);

        // R4: flags write sweep with all lines low
        for (int i = 0; i < 64; i++) begin
            logic [31:0] d;
            d = (32'(i) * 32'h85EB_CA6B) ^ 32'(i);
            bus_write(5'h00, d);
            m_flags = d & FMASK;
            bus_read(5'h00, rv); chk("R4 flags read mask", rv, m_flags);
            chk("R4 condition codes", {29'd0, flag_n, flag_c, flag_z}, {29'd0, d[2:0]});
        end

        // R3: unaligned and unmapped reads
        for (int a = 0; a < 32; a++) begin
            if (a != 5'h00 && a != 5'h14 && a != 5'h1C) begin
                remain_in = 32'hDEAD_BEEF;
                bus_read(5'(a), rv); chk("R3 unmapped read zero", rv, 0);
            end
        end

        // R11: writes elsewhere are ignored
        for (int a = 1; a < 32; a++) begin
            if (a != 5'h14) bus_write(5'(a), 32'hFFFF_FFFF);
        end
        bus_read(5'h00, rv); chk("R11 flags untouched", rv, m_flags);
        bus_read(5'h14, rv); chk("R11 ctrl untouched", rv, m_ctrl);

        // R2: remainder port and read data holding
        for (int i = 0; i < 8; i++) begin
            remain_in = 32'h1357_9BDF * 32'(i + 1);
            bus_read(5'h1C, rv); chk("R2 remainder read", rv, 32'h1357_9BDF * 32'(i + 1));
        end
        rv = bus_rdata;
        remain_in = 32'h0;
        repeat (3) @(negedge clk);
        chk("R2 rdata holds", bus_rdata, rv);

        // R6: clears while lines stay high
        ctrl_write(32'h1);
        irq_line = 5'h1F; @(negedge clk);
        bus_write(5'h00, (32'b00101 << 9) | (32'h1F << 4));
        m_flags = 32'h1F0;
        bus_read(5'h14, rv); chk("R6 partial clear", rv, m_ctrl | (32'b11010 << 6));
        bus_read(5'h00, rv); chk("R4 clear bits not stored", rv, m_flags);
        chk("R10 src after clear", {29'd0, irq_src}, 4);
        bus_write(5'h00, (32'h1F << 9) | (32'h1F << 4));
        chk("R6 full clear lines high", {31'd0, irq_pending}, 0);
        bus_read(5'h14, rv); chk("R6 latches zero", rv, m_ctrl);
        irq_line = 5'h1E; @(negedge clk);
        irq_line = 5'h1F;
        bus_write(5'h00, (32'h1 << 9) | (32'h1F << 4));
        bus_read(5'h14, rv); chk("R6 rise wins over clear", rv, m_ctrl | (32'h1 << 6));
        chk("R10 src single", {29'd0, irq_src}, 0);
        chk("R9 pending single", {31'd0, irq_pending}, 1);

        // R9: run gating
        ctrl_write(32'h0);
        chk("R9 pending gated by run", {31'd0, irq_pending}, 0);
        chk("R10 src gated by run", {29'd0, irq_src}, 0);
        ctrl_write(32'h1);
        chk("R9 pending with run", {31'd0, irq_pending}, 1);

        // R5, R9, R10: all enable masks against all line patterns
        irq_line = 5'h0; @(negedge clk);
        for (int e = 0; e < 32; e++) begin
            bus_write(5'h00, 32'(e) << 4);
            for (int l = 0; l < 32; l++) begin
                logic [4:0] lv;
                logic [4:0] p;
                lv = 5'((l * 7 + e * 3) & 31);
                p = lv & 5'(e);
                irq_line = lv; @(negedge clk);
                chk("R9 pending sweep", {31'd0, irq_pending}, {31'd0, |p});
                chk("R10 src sweep", {29'd0, irq_src}, top_src(p));
                bus_read(5'h14, rv); chk("R5 latch follows edges", rv, m_ctrl | (32'(lv) << 6));
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule